// File: doc/BRIEF.md
# PCI DMA Window Address Translator

This block turns an address seen on the PCI side into a 34-bit system DMA address. Software programs four windows through a 64-bit register port. Each window has three 64-bit registers: a base, a mask and a translated base. A window can pass the address through directly, or it can map it through scatter-gather. In scatter-gather mode the block reads a page-table entry from system memory before it forms the result.

A translation starts when `reqValid` meets `reqReady`. All four windows are compared in the same cycle, and the lowest-numbered enabled window that matches is chosen. A direct or unmatched translation finishes one cycle later. A scatter-gather translation first drives an entry-fetch request, holding it until the memory side accepts it. It then waits for the response and finishes one cycle after the response arrives. The block takes no new translation from the moment the fetch is issued until the fetch completes.

Top module: `pci_dma_xlate`

## Requirements
- R1: After reset, every window register reads 0, `reqReady` is 1, and `xlateDone` and `fetchReqValid` are 0.
- R2: The register slot is the byte offset shifted right by 6. Slots 0..3 hold the base of windows 0..3, slots 4..7 their masks, and slots 8..11 their translated bases. Each of these reads back what was last written. Any other slot reads 0, and writes to it have no effect.
- R3: An access whose byte enables are not all ones is ignored: a write leaves the register unchanged, and a read returns 0.
- R4: A window matches when it is enabled (bit 0 of its base is 1) and the bus address equals its base on every bit in 30..20 where the window's mask is 0. `xlateHit` reports a match.
- R5: When more than one enabled window matches, the lowest-numbered window is used.
- R6: A window whose base bit 1 is 0 maps directly. The pass mask is mask bits 30..20 OR 0xFFFFF. The result takes the bus address inside the pass mask and the translated base outside it. `xlateDone` is high in the cycle after the request is accepted.
- R7: With no enabled window matching, `xlateDone` is high in the cycle after acceptance, with `xlateHit` 0 and `xlateAddr` 0.
- R8: A matching window with base bit 1 set raises `fetchReqValid` in the cycle after acceptance. The entry address is the OR of two terms: (translated base AND NOT((mask bits 30..20 >> 10) OR 0x3FF)), and ((bus AND (mask bits 30..20 OR 0xFE000)) >> 10). Request and address hold until `fetchReqReady`.
- R9: The scatter-gather result is ((entry with bit 0 cleared) << 12) OR (bus bits 12..0). `xlateDone` is high with `xlateHit` 1 in the cycle after `fetchRspValid`.
- R10: Every result is cut to its low 34 bits, so bits of the translated base or of the entry above bit 33 never appear.
- R11: `reqReady` is 0 from fetch issue until the response is taken, and a request offered in that time is not accepted. `xlateDone` is a single-cycle pulse for each translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWrEn | input | 1 | Register write strobe |
| cfgRdEn | input | 1 | Register read strobe |
| cfgAddr | input | 10 | Register byte offset |
| cfgByteEn | input | 8 | Byte enables; only all ones is legal |
| cfgWrData | input | 64 | Register write data |
| cfgRdData | output | 64 | Register read data, combinational |
| reqValid | input | 1 | Translation request valid |
| reqReady | output | 1 | Translator can accept a request |
| reqAddr | input | 32 | PCI bus address to translate |
| fetchReqValid | output | 1 | Page-table entry fetch request |
| fetchReqReady | input | 1 | Memory accepts the fetch request |
| fetchReqAddr | output | 34 | Address of the page-table entry |
| fetchRspValid | input | 1 | Fetch response valid |
| fetchRspData | input | 64 | Fetched page-table entry |
| xlateDone | output | 1 | One-cycle completion strobe |
| xlateHit | output | 1 | A window matched |
| xlateAddr | output | 34 | Translated DMA address |

## Verification
A wrong window choice or a corrupt latched bus address shows at `xlateAddr` and `xlateHit` when `xlateDone` pulses: one cycle after acceptance for direct or missed translations, and one cycle after the response for scatter-gather ones. A wrong entry-address computation shows on `fetchReqAddr` in the first cycle of the fetch request. A control state stuck in the wrong place shows as a missing or doubled `xlateDone`, or as `reqReady` staying low, within a few cycles. Sweeping every value of bus bits 30..20 over two window setups reaches every window, every mode, overlap priority and the miss case.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

  localparam int REG_W = 64;

  // bit positions and masks fixed by the translation behaviour
  localparam int EN_BIT = 0;
  localparam int SG_BIT = 1;
  localparam logic [REG_W-1:0] WIN_FIELD  = 64'h0000_0000_7FF0_0000;
  localparam logic [REG_W-1:0] DIRECT_LOW = 64'h0000_0000_000F_FFFF;
  localparam logic [REG_W-1:0] PTE_LOW    = 64'h0000_0000_0000_03FF;
  localparam logic [REG_W-1:0] PTE_IDX    = 64'h0000_0000_000F_E000;
  localparam logic [REG_W-1:0] PAGE_OFS   = 64'h0000_0000_0000_1FFF;
  localparam int PTE_SHIFT  = 10;
  localparam int PAGE_SHIFT = 12;
  localparam int SLOT_SHIFT = 6;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_WAIT  = 2'd2
  } xlateState_t;

  typedef struct packed {
    logic capture;
    logic loadDirect;
    logic loadSg;
  } xlateStrobe_t;

endpackage

// File: rtl/xlate_cfg_regs.sv
module xlate_cfg_regs
  import xlate_pkg::*;
#(
  parameter int NUM_WIN = 4,
  parameter int CFG_AW  = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic             cfgRdEn,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [7:0]       cfgByteEn,
  input  logic [REG_W-1:0] cfgWrData,
  output logic [REG_W-1:0] cfgRdData,
  output logic [REG_W-1:0] winBase [NUM_WIN],
  output logic [REG_W-1:0] winMask [NUM_WIN],
  output logic [REG_W-1:0] winTba  [NUM_WIN]
);

  localparam int IDX_W = CFG_AW - SLOT_SHIFT;

  logic [IDX_W-1:0] slot;
  logic             fullAccess;

  assign slot       = cfgAddr[CFG_AW-1:SLOT_SHIFT];
  assign fullAccess = &cfgByteEn;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_reg
    localparam int BASE_SLOT = w;
    localparam int MASK_SLOT = NUM_WIN + w;
    localparam int TBA_SLOT  = 2 * NUM_WIN + w;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        winBase[w] <= '0;
        winMask[w] <= '0;
        winTba[w]  <= '0;
      end else if (cfgWrEn && fullAccess) begin
        if (slot == IDX_W'(BASE_SLOT)) winBase[w] <= cfgWrData;
        if (slot == IDX_W'(MASK_SLOT)) winMask[w] <= cfgWrData;
        if (slot == IDX_W'(TBA_SLOT))  winTba[w]  <= cfgWrData;
      end
    end
  end

  always_comb begin
    cfgRdData = '0;
    if (cfgRdEn && fullAccess) begin
      for (int w = 0; w < NUM_WIN; w++) begin
        if (slot == IDX_W'(w))               cfgRdData = winBase[w];
        if (slot == IDX_W'(NUM_WIN + w))     cfgRdData = winMask[w];
        if (slot == IDX_W'(2 * NUM_WIN + w)) cfgRdData = winTba[w];
      end
    end
  end

endmodule

// File: rtl/xlate_datapath.sv
module xlate_datapath
  import xlate_pkg::*;
#(
  parameter int NUM_WIN = 4,
  parameter int BUS_AW  = 32,
  parameter int DMA_AW  = 34
) (
  input  logic              clk,
  input  logic              rstN,
  input  xlateStrobe_t      strobe,
  input  logic [BUS_AW-1:0] reqAddr,
  input  logic [REG_W-1:0]  winBase [NUM_WIN],
  input  logic [REG_W-1:0]  winMask [NUM_WIN],
  input  logic [REG_W-1:0]  winTba  [NUM_WIN],
  input  logic [REG_W-1:0]  fetchRspData,
  output logic              anyHit,
  output logic              selSg,
  output logic [DMA_AW-1:0] fetchAddr,
  output logic [DMA_AW-1:0] xlateAddr,
  output logic              xlateHit
);

  localparam int SEL_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

  logic [REG_W-1:0]   busExt;
  logic [NUM_WIN-1:0] hitVec;
  logic [NUM_WIN-1:0] sgVec;
  logic [DMA_AW-1:0]  directAddr [NUM_WIN];
  logic [DMA_AW-1:0]  pteAddr    [NUM_WIN];
  logic [SEL_W-1:0]   selIdx;

  logic [BUS_AW-1:0]  busQ;
  logic [DMA_AW-1:0]  pteQ;
  logic [DMA_AW-1:0]  addrQ;
  logic               hitQ;
  logic [REG_W-1:0]   sgFull;

  assign busExt = REG_W'(reqAddr);

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic [REG_W-1:0] fieldBits;
    logic [REG_W-1:0] cmpMask;
    logic [REG_W-1:0] passMask;
    logic [REG_W-1:0] directFull;
    logic [REG_W-1:0] tblMask;
    logic [REG_W-1:0] idxMask;
    logic [REG_W-1:0] pteFull;

    assign fieldBits  = winMask[w] & WIN_FIELD;
    assign cmpMask    = ~winMask[w] & WIN_FIELD;
    assign hitVec[w]  = winBase[w][EN_BIT] &&
                        ((busExt & cmpMask) == (winBase[w] & cmpMask));
    assign sgVec[w]   = winBase[w][SG_BIT];

    assign passMask   = fieldBits | DIRECT_LOW;
    assign directFull = (winTba[w] & ~passMask) | (busExt & passMask);
    assign directAddr[w] = directFull[DMA_AW-1:0];

    assign tblMask    = ~((fieldBits >> PTE_SHIFT) | PTE_LOW);
    assign idxMask    = fieldBits | PTE_IDX;
    assign pteFull    = (winTba[w] & tblMask) | ((busExt & idxMask) >> PTE_SHIFT);
    assign pteAddr[w] = pteFull[DMA_AW-1:0];
  end

  // lowest-numbered matching window wins
  always_comb begin
    selIdx = '0;
    anyHit = 1'b0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hitVec[i]) begin
        selIdx = SEL_W'(i);
        anyHit = 1'b1;
      end
    end
  end

  assign selSg = sgVec[selIdx];

  assign sgFull = ({fetchRspData[REG_W-1:1], 1'b0} << PAGE_SHIFT) |
                  (REG_W'(busQ) & PAGE_OFS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busQ  <= '0;
      pteQ  <= '0;
      addrQ <= '0;
      hitQ  <= 1'b0;
    end else begin
      if (strobe.capture) begin
        busQ <= reqAddr;
        pteQ <= pteAddr[selIdx];
      end
      if (strobe.loadDirect) begin
        addrQ <= anyHit ? directAddr[selIdx] : '0;
        hitQ  <= anyHit;
      end else if (strobe.loadSg) begin
        addrQ <= sgFull[DMA_AW-1:0];
        hitQ  <= 1'b1;
      end
    end
  end

  assign fetchAddr = pteQ;
  assign xlateAddr = addrQ;
  assign xlateHit  = hitQ;

endmodule

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
  import xlate_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         anyHit,
  input  logic         selSg,
  input  logic         fetchReqReady,
  input  logic         fetchRspValid,
  output logic         reqReady,
  output logic         fetchReqValid,
  output logic         xlateDone,
  output xlateStrobe_t strobe
);

  xlateState_t stateQ, stateNext;
  logic        doneQ;

  always_comb begin
    stateNext = stateQ;
    strobe    = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.capture = 1'b1;
          if (anyHit && selSg) stateNext = ST_FETCH;
          else                 strobe.loadDirect = 1'b1;
        end
      end
      ST_FETCH: begin
        if (fetchReqReady) stateNext = ST_WAIT;
      end
      ST_WAIT: begin
        if (fetchRspValid) begin
          strobe.loadSg = 1'b1;
          stateNext     = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      doneQ  <= 1'b0;
    end else begin
      stateQ <= stateNext;
      doneQ  <= strobe.loadDirect | strobe.loadSg;
    end
  end

  assign reqReady      = (stateQ == ST_IDLE);
  assign fetchReqValid = (stateQ == ST_FETCH);
  assign xlateDone     = doneQ;

endmodule

// File: rtl/pci_dma_xlate.sv
module pci_dma_xlate
  import xlate_pkg::*;
#(
  parameter int NUM_WIN = 4,
  parameter int CFG_AW  = 10,
  parameter int BUS_AW  = 32,
  parameter int DMA_AW  = 34
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic              cfgRdEn,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [7:0]        cfgByteEn,
  input  logic [63:0]       cfgWrData,
  output logic [63:0]       cfgRdData,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [BUS_AW-1:0] reqAddr,
  output logic              fetchReqValid,
  input  logic              fetchReqReady,
  output logic [DMA_AW-1:0] fetchReqAddr,
  input  logic              fetchRspValid,
  input  logic [63:0]       fetchRspData,
  output logic              xlateDone,
  output logic              xlateHit,
  output logic [DMA_AW-1:0] xlateAddr
);

  logic [REG_W-1:0] winBase [NUM_WIN];
  logic [REG_W-1:0] winMask [NUM_WIN];
  logic [REG_W-1:0] winTba  [NUM_WIN];
  xlateStrobe_t     strobe;
  logic             anyHit;
  logic             selSg;

  xlate_cfg_regs #(.NUM_WIN(NUM_WIN), .CFG_AW(CFG_AW)) u_regs (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgRdEn(cfgRdEn),
    .cfgAddr(cfgAddr), .cfgByteEn(cfgByteEn), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .winBase(winBase), .winMask(winMask), .winTba(winTba)
  );

  xlate_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .anyHit(anyHit), .selSg(selSg),
    .fetchReqReady(fetchReqReady), .fetchRspValid(fetchRspValid),
    .reqReady(reqReady), .fetchReqValid(fetchReqValid), .xlateDone(xlateDone),
    .strobe(strobe)
  );

  xlate_datapath #(.NUM_WIN(NUM_WIN), .BUS_AW(BUS_AW), .DMA_AW(DMA_AW)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr),
    .winBase(winBase), .winMask(winMask), .winTba(winTba),
    .fetchRspData(fetchRspData), .anyHit(anyHit), .selSg(selSg),
    .fetchAddr(fetchReqAddr), .xlateAddr(xlateAddr), .xlateHit(xlateHit)
  );

endmodule

// File: rtl/pci_dma_xlate_chk.sv
module pci_dma_xlate_chk #(
  parameter int DMA_AW = 34
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              fetchReqValid,
  input logic              fetchReqReady,
  input logic [DMA_AW-1:0] fetchReqAddr,
  input logic              fetchRspValid,
  input logic              xlateDone,
  input logic              xlateHit,
  input logic [DMA_AW-1:0] xlateAddr
);

  // fetch handed over, response outstanding (tracked from ports only)
  logic waitQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) waitQ <= 1'b0;
    else if (fetchReqValid && fetchReqReady) waitQ <= 1'b1;
    else if (fetchRspValid) waitQ <= 1'b0;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rstN |=> (!xlateDone && !fetchReqValid && reqReady));

  assert_accept_responds_R6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (xlateDone || fetchReqValid));

  assert_miss_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    (xlateDone && !xlateHit) |-> (xlateAddr == '0));

  assert_fetch_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (fetchReqValid && !fetchReqReady) |=> (fetchReqValid && $stable(fetchReqAddr)));

  assert_sg_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    (waitQ && fetchRspValid) |=> (xlateDone && xlateHit));

  assert_busy_blocks_R11: assert property (@(posedge clk) disable iff (!rstN)
    (fetchReqValid || waitQ) |-> !reqReady);

endmodule

bind pci_dma_xlate pci_dma_xlate_chk #(.DMA_AW(DMA_AW)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .fetchReqValid(fetchReqValid), .fetchReqReady(fetchReqReady),
  .fetchReqAddr(fetchReqAddr), .fetchRspValid(fetchRspValid),
  .xlateDone(xlateDone), .xlateHit(xlateHit), .xlateAddr(xlateAddr)
);

// File: tb/pci_dma_xlate_tb.sv
module pci_dma_xlate_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] M34 = 64'h3_FFFF_FFFF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 0, cfgRdEn = 0;
  logic [9:0]  cfgAddr = '0;
  logic [7:0]  cfgByteEn = '0;
  logic [63:0] cfgWrData = '0, cfgRdData;
  logic        reqValid = 0, reqReady;
  logic [31:0] reqAddr = '0;
  logic        fetchReqValid, fetchReqReady = 0;
  logic [33:0] fetchReqAddr;
  logic        fetchRspValid = 0;
  logic [63:0] fetchRspData = '0;
  logic        xlateDone, xlateHit;
  logic [33:0] xlateAddr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [63:0] mBase [4];
  logic [63:0] mMask [4];
  logic [63:0] mTba  [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  pci_dma_xlate u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgRdEn(cfgRdEn), .cfgAddr(cfgAddr),
    .cfgByteEn(cfgByteEn), .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .fetchReqValid(fetchReqValid), .fetchReqReady(fetchReqReady),
    .fetchReqAddr(fetchReqAddr), .fetchRspValid(fetchRspValid),
    .fetchRspData(fetchRspData), .xlateDone(xlateDone), .xlateHit(xlateHit),
    .xlateAddr(xlateAddr)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfgWrite(input int slot, input logic [63:0] val, input logic [7:0] be);
    @(negedge clk);
    cfgWrEn = 1; cfgAddr = 10'(slot << 6); cfgWrData = val; cfgByteEn = be;
    @(negedge clk);
    cfgWrEn = 0; cfgByteEn = '0;
  endtask

  task automatic cfgRead(input int slot, input logic [7:0] be, output logic [63:0] val);
    @(negedge clk);
    cfgRdEn = 1; cfgAddr = 10'((slot << 6) | 6'h18); cfgByteEn = be;
    #1 val = cfgRdData;
    cfgRdEn = 0; cfgByteEn = '0;
  endtask

  task automatic setWin(input int w, input logic [63:0] b, input logic [63:0] m, input logic [63:0] t);
    mBase[w] = b; mMask[w] = m; mTba[w] = t;
    cfgWrite(w, b, 8'hFF);
    cfgWrite(4 + w, m, 8'hFF);
    cfgWrite(8 + w, t, 8'hFF);
  endtask

  // arithmetic model from the requirements
  task automatic model(input logic [31:0] bus, output int win, output bit sg,
                       output logic [63:0] pte, output logic [63:0] dir);
    logic [63:0] b64, fld, cm, pm, tm, im;
    b64 = {32'h0, bus};
    win = -1; sg = 0; pte = '0; dir = '0;
    for (int i = 3; i >= 0; i--) begin
      cm = ~mMask[i] & 64'h7FF0_0000;
      if (mBase[i][0] && ((b64 & cm) == (mBase[i] & cm))) win = i;
    end
    if (win >= 0) begin
      fld = mMask[win] & 64'h7FF0_0000;
      sg  = mBase[win][1];
      pm  = fld | 64'hF_FFFF;
      dir = ((mTba[win] & ~pm) | (b64 & pm)) & M34;
      tm  = ~((fld >> 10) | 64'h3FF);
      im  = fld | (64'h7F << 13);
      pte = ((mTba[win] & tm) | ((b64 & im) >> 10)) & M34;
    end
  endtask

  task automatic xlate(input logic [31:0] bus, input bit overlap);
    int win; bit sg;
    logic [63:0] pte, dir, data, expAddr;
    string at;
    model(bus, win, sg, pte, dir);
    @(negedge clk);
    chk(xlateDone == 0, "R11 done single pulse", 64'(xlateDone), 0);
    chk(reqReady == 1, "R11 ready when idle", 64'(reqReady), 1);
    reqValid = 1; reqAddr = bus;
    @(negedge clk);
    reqValid = 0;
    if (win < 0) begin
      chk(xlateDone && !xlateHit, "R7 miss done", {xlateDone, xlateHit}, 2'b10);
      chk(xlateAddr == 0, "R7 miss addr", 64'(xlateAddr), 0);
      chk(fetchReqValid == 0, "R7 no fetch", 64'(fetchReqValid), 0);
    end else if (!sg) begin
      at = overlap ? "R5 priority addr" : "R6/R10 direct addr";
      chk(xlateDone && xlateHit, "R4/R6 direct done+hit", {xlateDone, xlateHit}, 2'b11);
      chk(64'(xlateAddr) == dir, at, 64'(xlateAddr), dir);
    end else begin
      chk(fetchReqValid && !xlateDone, "R8 fetch issued", {fetchReqValid, xlateDone}, 2'b10);
      chk(64'(fetchReqAddr) == pte, "R8 entry addr", 64'(fetchReqAddr), pte);
      @(negedge clk);
      chk(fetchReqValid == 1, "R8 fetch held", 64'(fetchReqValid), 1);
      chk(64'(fetchReqAddr) == pte, "R8 entry addr held", 64'(fetchReqAddr), pte);
      chk(reqReady == 0, "R11 busy in fetch", 64'(reqReady), 0);
      fetchReqReady = 1;
      @(negedge clk);
      fetchReqReady = 0;
      chk(fetchReqValid == 0 && xlateDone == 0, "R9 waiting", {fetchReqValid, xlateDone}, 0);
      reqValid = 1; reqAddr = bus ^ 32'h0010_0000;   // offered while busy
      data = {8'hC5, 8'(bus[31:24]), 16'hA000, bus[19:0], 11'h0, bus[20]};
      fetchRspValid = 1; fetchRspData = data;
      @(negedge clk);
      fetchRspValid = 0; reqValid = 0;
      expAddr = (((data & ~64'h1) << 12) | ({32'h0, bus} & 64'h1FFF)) & M34;
      chk(xlateDone && xlateHit, "R9 sg done+hit", {xlateDone, xlateHit}, 2'b11);
      chk(64'(xlateAddr) == expAddr, "R9/R10 sg addr", 64'(xlateAddr), expAddr);
      chk(reqReady == 1, "R11 busy request not taken", 64'(reqReady), 1);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [63:0] v;
    for (int i = 0; i < 4; i++) begin mBase[i] = 0; mMask[i] = 0; mTba[i] = 0; end
    repeat (3) @(negedge clk);
    chk(reqReady == 1 && xlateDone == 0 && fetchReqValid == 0, "R1 reset outputs",
        {reqReady, xlateDone, fetchReqValid}, 3'b100);
    rstN = 1;
    for (int s = 0; s < 12; s++) begin
      cfgRead(s, 8'hFF, v);
      chk(v == 0, "R1 reset register", v, 0);
    end

    // register map, unused slot, partial access
    for (int s = 0; s < 12; s++) cfgWrite(s, 64'h1111_0000_0000_0000 * (s + 1) + 64'(s), 8'hFF);
    for (int s = 0; s < 12; s++) begin
      cfgRead(s, 8'hFF, v);
      chk(v == 64'h1111_0000_0000_0000 * (s + 1) + 64'(s), "R2 readback", v,
          64'h1111_0000_0000_0000 * (s + 1) + 64'(s));
    end
    cfgWrite(12, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF);
    cfgRead(12, 8'hFF, v);
    chk(v == 0, "R2 unused slot", v, 0);
    for (int s = 0; s < 12; s++) begin
      cfgRead(s, 8'hFF, v);
      chk(v == 64'h1111_0000_0000_0000 * (s + 1) + 64'(s), "R2 unused write no effect", v,
          64'h1111_0000_0000_0000 * (s + 1) + 64'(s));
    end
    cfgWrite(5, 64'hDEAD_BEEF, 8'h0F);
    cfgRead(5, 8'hFF, v);
    chk(v == 64'h6666_0000_0000_0005, "R3 partial write ignored", v, 64'h6666_0000_0000_0005);
    cfgRead(5, 8'h7F, v);
    chk(v == 0, "R3 partial read zero", v, 0);

    // setup A: direct w0 inside direct w2, sg w1, disabled w3
    setWin(0, 64'h0010_0001, 64'h0,        64'hFF00_0012_3450_0000);
    setWin(1, 64'h4000_0003, 64'h3FF0_0000, 64'h0000_0003_0005_5000);
    setWin(2, 64'h0000_0001, 64'h0FF0_0000, 64'h0000_0001_8000_0000);
    setWin(3, 64'h2000_0002, 64'h1FF0_0000, 64'h0000_0002_0000_0000);
    for (int hi = 0; hi < 2048; hi++)
      xlate({1'b0, 11'(hi), 20'((hi * 32'h9E37) ^ 32'h5A5A5)}, hi == 1);

    // setup B: w0 off, direct w1, sg w3 enabled, w2 unchanged
    setWin(0, 64'h0010_0000, 64'h0,        64'h0);
    setWin(1, 64'h4000_0001, 64'h1FF0_0000, 64'hF000_0002_0000_0000);
    setWin(3, 64'h2000_0003, 64'h1FF0_0000, 64'hFFFF_FFF1_2345_6000);
    for (int hi = 0; hi < 2048; hi += 3)
      xlate({1'b0, 11'(hi), 20'((hi * 32'h3C6EF) ^ 32'hFFFFF)}, 1'b0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule